// File: doc/BRIEF.md
# SPI Master Clock and Chip-Select Timer

This block produces the serial clock, the active-low peripheral select and the data strobes of an SPI master. It runs from the system clock and needs no other timing reference. A frame is requested with a single-cycle start. The block then asserts the select and waits a programmed setup time. It clocks out a programmed number of bits, waits a programmed hold time after the final clock edge, releases the select, and reports completion with a one-cycle pulse.

Three independent pairs of codes set the timing. A prescaler code and a scaler code set the bit period, and a double-rate bit halves that period. Two further prescaler and scaler pairs set the setup and hold delays. Clock polarity and phase are inputs. All settings are captured when a frame is accepted. The shifting logic that sits beside this block uses the sample and shift strobes to move data at the right edges.

Top module: `spi_clk_timer`

## Requirements
- R1: The baud prescaler code maps 0→2, 1→3, 2→5, 3→7. The baud scaler code maps 0→2, 1→4, 2→6, and any code c≥3 maps to 2^c. The bit period is prescaler×scaler system cycles with `dbl_rate`=0, and half of that with `dbl_rate`=1. So codes 0/0 give a 4-cycle period, or 2 cycles at double rate.
- R2: With `dbl_rate`=0 the two halves of every bit are equal. With an odd period, the half in which `sck` is high is one cycle longer than the half in which it is low.
- R3: The setup prescaler maps 0→1, 1→3, 2→5, 3→7, and a setup scaler code n maps to 2^(n+1). The first `sck` change occurs prescaler×scaler cycles after the first cycle in which `pcs_n` is low. Codes 1 and 4 give 96 cycles.
- R4: The hold prescaler and scaler use the same maps as in R3. `pcs_n` rises prescaler×scaler cycles after the last `sck` change.
- R5: While no frame is running, `sck` equals `cpol` one cycle after `cpol` is presented. Within a frame, `sck` starts and ends at the captured `cpol` level.
- R6: Every `sck` change lasts exactly one cycle and is marked in the same cycle by one strobe. With `cpha`=0, leading edges (idle to active) raise `sample_stb` and trailing edges raise `shift_stb`. With `cpha`=1 the roles are swapped. Neither strobe is raised outside a frame.
- R7: `frame_bits` sets the number of clock pulses. Values below 4 are treated as 4, and values above 16 as 16.
- R8: `done` is high for one cycle, in the cycle after the first cycle with `pcs_n` high again.
- R9: A `start` is ignored from the cycle it is accepted until `done`. A `start` presented in the `done` cycle is accepted.
- R10: Every timing, count and mode input is captured with the accepted `start`. Later changes do not alter the running frame.
- R11: During reset `pcs_n` is high, `sck` is low, and `done` and both strobes are low.
- R12: `pcs_n` goes low in the cycle after `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame request, sampled when idle |
| frame_bits | input | 5 | Bits per frame, clamped to 4..16 |
| baud_pre | input | 2 | Bit-period prescaler code |
| baud_scl | input | 4 | Bit-period scaler code |
| dbl_rate | input | 1 | Halves the bit period |
| setup_pre | input | 2 | Select-to-clock delay prescaler code |
| setup_scl | input | 4 | Select-to-clock delay scaler code |
| hold_pre | input | 2 | Clock-to-deselect delay prescaler code |
| hold_scl | input | 4 | Clock-to-deselect delay scaler code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Selects which edge samples and which shifts |
| sck | output | 1 | Serial clock |
| pcs_n | output | 1 | Peripheral select, active low |
| sample_stb | output | 1 | Pulse on the edge where input data is captured |
| shift_stb | output | 1 | Pulse on the edge where output data changes |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Two events can land in the same cycle: the completion pulse of one frame and the start request of the next. The bench sets up this case by issuing each new request in the very negedge where it sees `done`. It then requires `pcs_n` to fall exactly one cycle later, with the new frame's setup delay counted from there. The reverse case is a request arriving inside a frame, together with new settings. It is judged by the count of `pcs_n` falling edges and by edge timing that still matches the captured settings.

// File: rtl/spi_tmr_pkg.sv
// Package: shared state type and code-to-value maps of the SPI clock timer.
// Assumes: codes are the raw field values; returned values are cycle counts.
package spi_tmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_HOLD,
        ST_FINISH
    } seq_state_t;

    // Bit-period prescaler: small odd-ish set of divisors.
    function automatic int unsigned baud_pre_val(input logic [1:0] code);
        case (code)
            2'd0:    return 32'd2;
            2'd1:    return 32'd3;
            2'd2:    return 32'd5;
            default: return 32'd7;
        endcase
    endfunction

    // Bit-period scaler: linear for the first three codes, power of two above.
    function automatic int unsigned baud_scl_val(input logic [3:0] code);
        if (code < 4'd3)
            return 32'd2 * (32'(code) + 32'd1);
        else
            return 32'd1 << code;
    endfunction

    // Delay prescaler (setup and hold).
    function automatic int unsigned dly_pre_val(input logic [1:0] code);
        case (code)
            2'd0:    return 32'd1;
            2'd1:    return 32'd3;
            2'd2:    return 32'd5;
            default: return 32'd7;
        endcase
    endfunction

    // Delay scaler (setup and hold): two to the power code plus one.
    function automatic int unsigned dly_scl_val(input logic [3:0] code);
        return 32'd2 << code;
    endfunction

endpackage

// File: rtl/spi_tmr_calc.sv
// Module: spi_tmr_calc
// Turns the live code inputs into phase and delay lengths in system cycles.
// Assumes: CNT_W holds the largest product (7 x 65536); purely combinational,
// the sequencer captures the results when it accepts a frame.
module spi_tmr_calc
    import spi_tmr_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic [1:0]       baud_pre,
    input  logic [3:0]       baud_scl,
    input  logic             dbl_rate,
    input  logic [1:0]       setup_pre,
    input  logic [3:0]       setup_scl,
    input  logic [1:0]       hold_pre,
    input  logic [3:0]       hold_scl,
    input  logic             cpol,
    output logic [CNT_W-1:0] lead_len,
    output logic [CNT_W-1:0] trail_len,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] hold_len
);

    int unsigned prod;
    int unsigned period;
    int unsigned half_up;
    int unsigned half_dn;

    // Bit period and its split into the high-longer halves.
    always_comb begin
        prod    = baud_pre_val(baud_pre) * baud_scl_val(baud_scl);
        period  = dbl_rate ? (prod >> 1) : prod;
        half_up = (period + 32'd1) >> 1;
        half_dn = period >> 1;
    end

    // Active half follows the idle level: with idle low the active half is high.
    always_comb begin
        lead_len  = CNT_W'(cpol ? half_dn : half_up);
        trail_len = CNT_W'(cpol ? half_up : half_dn);
    end

    // Setup and hold delays, each its own prescaler by scaler product.
    always_comb begin
        setup_len = CNT_W'(dly_pre_val(setup_pre) * dly_scl_val(setup_scl));
        hold_len  = CNT_W'(dly_pre_val(hold_pre) * dly_scl_val(hold_scl));
    end

endmodule

// File: rtl/spi_tmr_seq.sv
// Module: spi_tmr_seq
// Frame sequencer: select assertion, setup wait, clock pulses, hold wait,
// deselect, completion pulse. One shared down-counter times every segment.
// Assumes: all lengths are at least 1 (guaranteed by the code maps); settings
// are captured on the accepted start; outputs come straight from flops.
module spi_tmr_seq
    import spi_tmr_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int BITS_W   = 5,
    parameter int MIN_BITS = 4,
    parameter int MAX_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] frame_bits,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [CNT_W-1:0]  lead_len,
    input  logic [CNT_W-1:0]  trail_len,
    input  logic [CNT_W-1:0]  setup_len,
    input  logic [CNT_W-1:0]  hold_len,
    output logic              sck,
    output logic              pcs_n,
    output logic              done,
    output logic              lead_evt,
    output logic              trail_evt,
    output logic              cpha_q
);

    localparam logic [BITS_W-1:0] LO_BITS = BITS_W'(MIN_BITS);
    localparam logic [BITS_W-1:0] HI_BITS = BITS_W'(MAX_BITS);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BITS_W-1:0] bit_idx;
    logic [BITS_W-1:0] nbits_q;
    logic [BITS_W-1:0] nbits_eff;
    logic [CNT_W-1:0]  lead_q;
    logic [CNT_W-1:0]  trail_q;
    logic [CNT_W-1:0]  hold_q;
    logic              cpol_q;
    logic              in_lead;
    logic              last_bit;
    logic              cnt_zero;

    // Clamp the requested bit count into the supported range.
    always_comb begin
        if (frame_bits < LO_BITS)
            nbits_eff = LO_BITS;
        else if (frame_bits > HI_BITS)
            nbits_eff = HI_BITS;
        else
            nbits_eff = frame_bits;
    end

    // Segment-end and edge decode shared by the state update and the strobes.
    always_comb begin
        cnt_zero  = (cnt == '0);
        last_bit  = (bit_idx == nbits_q - 1'b1);
        lead_evt  = cnt_zero && ((state == ST_SETUP) || (state == ST_XFER && !in_lead));
        trail_evt = cnt_zero && (state == ST_XFER) && in_lead;
    end

    // Frame state, segment counter and registered pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            nbits_q <= LO_BITS;
            lead_q  <= '0;
            trail_q <= '0;
            hold_q  <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            in_lead <= 1'b0;
            sck     <= 1'b0;
            pcs_n   <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    sck <= cpol;
                    if (start) begin
                        cpol_q  <= cpol;
                        cpha_q  <= cpha;
                        nbits_q <= nbits_eff;
                        lead_q  <= lead_len;
                        trail_q <= trail_len;
                        hold_q  <= hold_len;
                        bit_idx <= '0;
                        cnt     <= setup_len - 1'b1;
                        pcs_n   <= 1'b0;
                        state   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt_zero) begin
                        sck     <= ~cpol_q;
                        in_lead <= 1'b1;
                        cnt     <= lead_q - 1'b1;
                        state   <= ST_XFER;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (in_lead) begin
                        sck <= cpol_q;
                        if (last_bit) begin
                            cnt   <= hold_q - 1'b1;
                            state <= ST_HOLD;
                        end else begin
                            in_lead <= 1'b0;
                            cnt     <= trail_q - 1'b1;
                        end
                    end else begin
                        sck     <= ~cpol_q;
                        in_lead <= 1'b1;
                        bit_idx <= bit_idx + 1'b1;
                        cnt     <= lead_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_zero) begin
                        pcs_n <= 1'b1;
                        state <= ST_FINISH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_tmr_strobe.sv
// Module: spi_tmr_strobe
// Maps clock edges to sample and shift pulses according to the captured phase.
// Assumes: edge events arrive one cycle before the edge shows on the pin, so
// registering here lines the pulses up with the pin change.
module spi_tmr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_evt,
    input  logic trail_evt,
    input  logic cpha_q,
    output logic sample_stb,
    output logic shift_stb
);

    // Phase 0 samples on leading edges, phase 1 on trailing edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else begin
            sample_stb <= cpha_q ? trail_evt : lead_evt;
            shift_stb  <= cpha_q ? lead_evt  : trail_evt;
        end
    end

endmodule

// File: rtl/spi_clk_timer.sv
// Module: spi_clk_timer (top)
// SPI master clock and chip-select timer: code decode, frame sequencer and
// strobe generation. Assumes a single clock domain and synchronous reset.
module spi_clk_timer #(
    parameter int CNT_W    = 20,
    parameter int BITS_W   = 5,
    parameter int MIN_BITS = 4,
    parameter int MAX_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] frame_bits,
    input  logic [1:0]        baud_pre,
    input  logic [3:0]        baud_scl,
    input  logic              dbl_rate,
    input  logic [1:0]        setup_pre,
    input  logic [3:0]        setup_scl,
    input  logic [1:0]        hold_pre,
    input  logic [3:0]        hold_scl,
    input  logic              cpol,
    input  logic              cpha,
    output logic              sck,
    output logic              pcs_n,
    output logic              sample_stb,
    output logic              shift_stb,
    output logic              done
);

    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] trail_len;
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] hold_len;
    logic             lead_evt;
    logic             trail_evt;
    logic             cpha_q;

    spi_tmr_calc #(.CNT_W(CNT_W)) u_calc (
        .baud_pre  (baud_pre),
        .baud_scl  (baud_scl),
        .dbl_rate  (dbl_rate),
        .setup_pre (setup_pre),
        .setup_scl (setup_scl),
        .hold_pre  (hold_pre),
        .hold_scl  (hold_scl),
        .cpol      (cpol),
        .lead_len  (lead_len),
        .trail_len (trail_len),
        .setup_len (setup_len),
        .hold_len  (hold_len)
    );

    spi_tmr_seq #(
        .CNT_W    (CNT_W),
        .BITS_W   (BITS_W),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_bits (frame_bits),
        .cpol       (cpol),
        .cpha       (cpha),
        .lead_len   (lead_len),
        .trail_len  (trail_len),
        .setup_len  (setup_len),
        .hold_len   (hold_len),
        .sck        (sck),
        .pcs_n      (pcs_n),
        .done       (done),
        .lead_evt   (lead_evt),
        .trail_evt  (trail_evt),
        .cpha_q     (cpha_q)
    );

    spi_tmr_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lead_evt   (lead_evt),
        .trail_evt  (trail_evt),
        .cpha_q     (cpha_q),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

endmodule

// File: rtl/spi_clk_timer_chk.sv
// Module: spi_clk_timer_chk
// Port-level protocol properties of the timer, attached by bind.
module spi_clk_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic pcs_n,
    input logic sample_stb,
    input logic shift_stb,
    input logic done
);

    a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcs_n) |=> done);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_while_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pcs_n && $past(pcs_n)));

    a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));

    a_r6_strobe_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || shift_stb) |-> (sck != $past(sck)));

    a_r6_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        pcs_n |-> !(sample_stb || shift_stb));

endmodule

bind spi_clk_timer spi_clk_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .pcs_n      (pcs_n),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .done       (done)
);

// File: tb/spi_clk_timer_tb.sv
`timescale 1ns/1ps
module spi_clk_timer_tb;

    typedef struct {
        logic [1:0] bp;
        logic [3:0] bs;
        logic       dbr;
        logic [1:0] sp;
        logic [3:0] ss;
        logic [1:0] hp;
        logic [3:0] hs;
        logic       pol;
        logic       pha;
        logic [4:0] nb;
    } cfg_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] frame_bits = 5'd8;
    logic [1:0] baud_pre = '0;
    logic [3:0] baud_scl = '0;
    logic       dbl_rate = 1'b0;
    logic [1:0] setup_pre = '0;
    logic [3:0] setup_scl = '0;
    logic [1:0] hold_pre = '0;
    logic [3:0] hold_scl = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sck, pcs_n, sample_stb, shift_stb, done;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_clk_timer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_bits(frame_bits),
        .baud_pre(baud_pre), .baud_scl(baud_scl), .dbl_rate(dbl_rate),
        .setup_pre(setup_pre), .setup_scl(setup_scl),
        .hold_pre(hold_pre), .hold_scl(hold_scl),
        .cpol(cpol), .cpha(cpha),
        .sck(sck), .pcs_n(pcs_n), .sample_stb(sample_stb),
        .shift_stb(shift_stb), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference maps written from the requirements.
    function automatic int e_bpre(input logic [1:0] c);
        int t[4] = '{2, 3, 5, 7};
        return t[c];
    endfunction
    function automatic int e_bscl(input logic [3:0] c);
        if (c == 0) return 2;
        if (c == 1) return 4;
        if (c == 2) return 6;
        return 2 ** int'(c);
    endfunction
    function automatic int e_dpre(input logic [1:0] c);
        return 2 * int'(c) + ((c == 0) ? 1 : 1);
    endfunction
    function automatic int e_dscl(input logic [3:0] c);
        return 2 ** (int'(c) + 1);
    endfunction

    function automatic cfg_t mk(input int bp, input int bs, input int dbr,
                                input int sp, input int ss, input int hp,
                                input int hs, input int pol, input int pha,
                                input int nb);
        cfg_t c;
        c.bp = 2'(bp); c.bs = 4'(bs); c.dbr = 1'(dbr);
        c.sp = 2'(sp); c.ss = 4'(ss); c.hp = 2'(hp); c.hs = 4'(hs);
        c.pol = 1'(pol); c.pha = 1'(pha); c.nb = 5'(nb);
        return c;
    endfunction

    function automatic cfg_t rand_cfg();
        return mk($urandom % 4, $urandom % 5, $urandom % 2, $urandom % 4,
                  $urandom % 5, $urandom % 4, $urandom % 5, $urandom % 2,
                  $urandom % 2, $urandom % 21);
    endfunction

    task automatic apply(input cfg_t c);
        baud_pre = c.bp; baud_scl = c.bs; dbl_rate = c.dbr;
        setup_pre = c.sp; setup_scl = c.ss; hold_pre = c.hp; hold_scl = c.hs;
        cpol = c.pol; cpha = c.pha; frame_bits = c.nb;
    endtask

    // Issues start in the current negedge and follows the frame to its done pulse.
    task automatic run_frame(input cfg_t c, input bit disturb);
        int per, ld, dsu, dho, nb, c0, t0, t1, td, edges, nfall, last_rel;
        int e_time, e_lvl, e_stb, bad_act, bad_exp, rel, expt;
        bit lead, edge_now, exp_s, exp_h;
        logic sck_prev, pcs_prev;
        nb  = (c.nb < 4) ? 4 : ((c.nb > 16) ? 16 : int'(c.nb));
        per = e_bpre(c.bp) * e_bscl(c.bs);
        if (c.dbr) per = per / 2;
        ld  = c.pol ? per / 2 : (per + 1) / 2;
        dsu = e_dpre(c.sp) * e_dscl(c.ss);
        dho = e_dpre(c.hp) * e_dscl(c.hs);
        apply(c);
        start = 1'b1;
        c0 = cyc;
        pcs_prev = pcs_n; sck_prev = c.pol;
        t0 = -1; t1 = -1; td = -1; edges = 0; nfall = 0; last_rel = 0;
        e_time = 0; e_lvl = 0; e_stb = 0; bad_act = 0; bad_exp = 0;
        for (int k = 0; k < 12000 && td < 0; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = 1'b0;
                chk(sck === c.pol, "R5", "level at select", int'(sck), int'(c.pol));
            end
            if (disturb && k == 2) begin
                apply(rand_cfg());
                start = 1'b1;
            end
            if (disturb && k == 5) start = 1'b0;
            if (pcs_prev === 1'b1 && pcs_n === 1'b0) begin
                nfall++;
                if (t0 < 0) t0 = cyc;
            end
            if (pcs_prev === 1'b0 && pcs_n === 1'b1) t1 = cyc;
            edge_now = (t0 >= 0) && (sck !== sck_prev);
            lead = (edges % 2) == 0;
            if (edge_now) begin
                rel  = cyc - t0;
                expt = dsu + (edges / 2) * per + (lead ? 0 : ld);
                if (rel != expt && e_time == 0) begin
                    bad_act = rel; bad_exp = expt;
                end
                if (rel != expt) e_time++;
                if (sck !== (lead ? ~c.pol : c.pol)) e_lvl++;
                last_rel = rel;
                edges++;
            end
            exp_s = edge_now && (lead == !c.pha);
            exp_h = edge_now && !exp_s;
            if (sample_stb !== exp_s || shift_stb !== exp_h) e_stb++;
            if (done === 1'b1) td = cyc;
            pcs_prev = pcs_n; sck_prev = sck;
        end
        chk(t0 == c0 + 1, "R12", "select asserted cycle", t0, c0 + 1);
        chk(edges == 2 * nb, "R7", "sck edge count", edges, 2 * nb);
        chk(e_time == 0, "R1", "edge timing (first bad edge offset)", bad_act, bad_exp);
        chk(e_lvl == 0, "R2", "edge level mismatches", e_lvl, 0);
        chk(e_stb == 0, "R6", "strobe mismatches", e_stb, 0);
        chk(t1 - t0 - last_rel == dho, "R4", "hold delay", t1 - t0 - last_rel, dho);
        chk(td == t1 + 1, "R8", "done cycle", td, t1 + 1);
        if (disturb) begin
            chk(nfall == 1, "R9", "select falls in frame", nfall, 1);
            chk(e_time == 0 && edges == 2 * nb, "R10", "timing kept after input change",
                e_time, 0);
        end
    endtask

    // Idle cycles: select stays released and sck follows a changed polarity.
    task automatic idle_pol(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpol = ~cpol;
            @(negedge clk);
            chk(sck === cpol, "R5", "idle sck follows cpol", int'(sck), int'(cpol));
            chk(pcs_n === 1'b1 && done === 1'b0, "R8", "released and no done when idle",
                int'(done), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual %0d cycles expected done earlier", cyc);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(pcs_n === 1'b1 && sck === 1'b0, "R11", "reset pins",
            int'({pcs_n, sck}), 2);
        chk(done === 1'b0 && sample_stb === 1'b0 && shift_stb === 1'b0, "R11",
            "reset pulses", int'({done, sample_stb, shift_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Quarter rate, setup of 96 cycles (R3), hold of 2.
        run_frame(mk(0, 0, 0, 1, 4, 0, 0, 0, 0, 8), 1'b0);
        // Started in the done cycle (R9): double rate, period 2, phase 1.
        run_frame(mk(0, 0, 1, 0, 0, 1, 1, 0, 1, 8), 1'b0);
        // Odd period of 3, idle low then idle high (R2).
        run_frame(mk(1, 0, 1, 2, 0, 0, 1, 0, 0, 5), 1'b0);
        run_frame(mk(1, 0, 1, 2, 0, 0, 1, 1, 1, 5), 1'b0);
        idle_pol(2);
        // Power-of-two scaler code 5 and bit count below range (R1, R7).
        run_frame(mk(0, 5, 0, 0, 1, 3, 0, 0, 1, 2), 1'b0);
        // Bit count above range (R7), slow prescaler.
        run_frame(mk(3, 2, 0, 3, 2, 2, 3, 1, 0, 20), 1'b0);
        // Start and new settings inside a running frame (R9, R10).
        run_frame(mk(2, 1, 0, 1, 1, 1, 1, 0, 0, 6), 1'b1);
        idle_pol(1);
        for (int i = 0; i < 30; i++) begin
            run_frame(rand_cfg(), ($urandom % 3) == 0);
            if ($urandom % 2) idle_pol(1);
        end
        summary();
        $finish;
    end

endmodule